// File: doc/BRIEF.md
# Zero-Transition Sequential Address Link

This block is a matched transmitter and receiver for a parallel address bus. Next to the address lines it drives one extra wire, the sequential flag. Each valid cycle the transmitter compares the new address with the last address it accepted plus a fixed stride. On a match it leaves the address lines where they are and raises the flag. Otherwise it puts the real address on the lines and lowers the flag. Over a long run of consecutive fetches the address lines do not toggle at all.

The receiver keeps the last address it rebuilt. When the flag is high it adds the stride to that value. When the flag is low it takes the bus value as it is. The two halves sit in one wrapper, so the bus itself can be watched at the ports. Address width and stride are parameters, and all address arithmetic wraps modulo 2^width. An asynchronous active-low reset is released on the clock edge through a small synchroniser.

Top module: `seqenc_link`

## Requirements
- R1: While reset is held and until the first valid input, `bus_addr`, `bus_inc`, `bus_valid`, `out_valid` and `out_addr` are all 0. Both last-address registers start at 0.
- R2: A valid input equal to the previous accepted address plus `STRIDE` gives, one cycle later, `bus_inc`=1 with `bus_addr` unchanged from the cycle before.
- R3: Any other valid input gives, one cycle later, `bus_inc`=0 and `bus_addr` equal to that input.
- R4: Every valid input comes out again on `out_addr`, with `out_valid`=1, two cycles after it was presented.
- R5: The consecutive test wraps modulo 2^`ADDR_W`: when the previous address is 2^`ADDR_W`-`STRIDE`, an input of 0 counts as sequential.
- R6: A cycle with `in_valid`=0 gives `bus_valid`=0 one cycle later and `out_valid`=0 two cycles later. `bus_addr`, `bus_inc` and `out_addr` keep their values, and the next comparison still uses the last valid address.
- R7: After reset, a first valid address equal to `STRIDE` is sent as sequential (`bus_inc`=1, `bus_addr` stays 0).
- R8: Over an unbroken run of consecutive addresses that follows one explicit address, no bit of `bus_addr` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source address is valid this cycle |
| in_addr | input | ADDR_W | Source address |
| bus_addr | output | ADDR_W | Encoded bus address lines |
| bus_inc | output | 1 | Sequential flag: 1 = receiver adds the stride, 0 = use bus_addr |
| bus_valid | output | 1 | Bus word is valid this cycle |
| out_valid | output | 1 | Rebuilt address is valid |
| out_addr | output | ADDR_W | Rebuilt address |

## Verification
Bus results (`bus_addr`, `bus_inc`, `bus_valid`) follow an input by one clock edge. Rebuilt results (`out_addr`, `out_valid`) follow it by two. The bench drives each input just after a falling edge and samples on the next falling edge. At that moment it compares the bus against a model of the current input, and the receiver outputs against the input it drove one step earlier. Because of this fixed offset each check looks at exactly one register stage. Idle cycles are checked in the same way, with a model that holds its state.

// File: rtl/seqenc_pkg.sv
package seqenc_pkg;
  typedef enum logic {
    LINE_RAW = 1'b0,
    LINE_SEQ = 1'b1
  } inc_mode_e;
endpackage

// File: rtl/seqenc_rst_sync.sv
module seqenc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/seqenc_tx.sv
module seqenc_tx
  import seqenc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_inc,
  output logic              bus_valid
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] last_q, last_d;
  inc_mode_e         inc_q, inc_d;
  logic              valid_q;
  logic              load_en;
  logic [ADDR_W-1:0] predicted;

  assign load_en   = in_valid;
  assign predicted = last_q + STEP;

  always_comb begin
    addr_d = addr_q;
    inc_d  = inc_q;
    last_d = last_q;
    if (in_valid) begin
      last_d = in_addr;
      if (in_addr == predicted) begin
        inc_d = LINE_SEQ;
      end else begin
        inc_d  = LINE_RAW;
        addr_d = in_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      last_q  <= '0;
      inc_q   <= LINE_RAW;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (load_en) begin
        addr_q <= addr_d;
        last_q <= last_d;
        inc_q  <= inc_d;
      end
    end
  end

  assign bus_addr  = addr_q;
  assign bus_inc   = inc_q;
  assign bus_valid = valid_q;

  // R2
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_inc) |-> $stable(bus_addr));

  // R3
  raw_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (bus_valid && (bus_inc || bus_addr == $past(in_addr))));

  // R6
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!bus_valid && $stable(bus_addr) && $stable(bus_inc)));
endmodule

// File: rtl/seqenc_rx.sv
module seqenc_rx
  import seqenc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_inc,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

  logic [ADDR_W-1:0] rec_q, rec_d;
  logic              ov_q;
  logic              load_en;
  inc_mode_e         mode;

  assign load_en = bus_valid;
  assign mode    = inc_mode_e'(bus_inc);

  always_comb begin
    rec_d = rec_q;
    if (bus_valid) begin
      if (mode == LINE_SEQ) rec_d = rec_q + STEP;
      else                  rec_d = bus_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      ov_q <= bus_valid;
      if (load_en) rec_q <= rec_d;
    end
  end

  assign out_valid = ov_q;
  assign out_addr  = rec_q;

  // R4
  rx_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_inc) |=> (out_valid && out_addr == $past(bus_addr)));

  // R6
  rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (!out_valid && $stable(out_addr)));
endmodule

// File: rtl/seqenc_link.sv
module seqenc_link #(
  parameter int ADDR_W      = 32,
  parameter int STRIDE      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_inc,
  output logic              bus_valid,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr
);
  logic rst_n_int;

  seqenc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  seqenc_tx #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .bus_addr  (bus_addr),
    .bus_inc   (bus_inc),
    .bus_valid (bus_valid)
  );

  seqenc_rx #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_inc   (bus_inc),
    .out_valid (out_valid),
    .out_addr  (out_addr)
  );
endmodule

// File: tb/sim_seqenc_link.sv
module sim_seqenc_link;
  localparam int W      = 16;
  localparam int STRIDE = 4;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_addr;
  logic [W-1:0] bus_addr;
  logic         bus_inc;
  logic         bus_valid;
  logic         out_valid;
  logic [W-1:0] out_addr;

  int n_chk  = 0;
  int n_fail = 0;

  logic [W-1:0] m_last = '0;
  logic [W-1:0] m_bus  = '0;
  logic         m_inc  = 1'b0;
  logic [W-1:0] m_out  = '0;
  logic         pv     = 1'b0;
  logic [W-1:0] pa     = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seqenc_link #(.ADDR_W(W), .STRIDE(STRIDE)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .bus_addr(bus_addr), .bus_inc(bus_inc), .bus_valid(bus_valid),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  function automatic logic [W-1:0] next_addr(input logic [W-1:0] a);
    return a + W'(STRIDE);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [W-1:0] a, input string req);
    logic e_ov;
    in_valid = v;
    in_addr  = a;
    @(posedge clk);
    @(negedge clk);
    if (v) begin
      if (a == next_addr(m_last)) m_inc = 1'b1;
      else begin m_inc = 1'b0; m_bus = a; end
      m_last = a;
    end
    e_ov = pv;
    if (pv) m_out = pa;
    chk(bus_valid == v, {req, " bus_valid"}, 32'(bus_valid), 32'(v));
    chk(bus_inc == m_inc, {req, " bus_inc"}, 32'(bus_inc), 32'(m_inc));
    chk(bus_addr == m_bus, {req, " bus_addr"}, 32'(bus_addr), 32'(m_bus));
    chk(out_valid == e_ov, "R4/R6 out_valid", 32'(out_valid), 32'(e_ov));
    chk(out_addr == m_out, "R4/R6 out_addr", 32'(out_addr), 32'(m_out));
    pv = v;
    pa = a;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] cur;
    logic [W-1:0] run_start;
    int toggles;
    void'($urandom(32'd20240611));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_addr  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(bus_addr == '0, "R1 bus_addr", 32'(bus_addr), 0);
    chk(bus_inc == 1'b0, "R1 bus_inc", 32'(bus_inc), 0);
    chk(bus_valid == 1'b0, "R1 bus_valid", 32'(bus_valid), 0);
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    chk(out_addr == '0, "R1 out_addr", 32'(out_addr), 0);
    rst_n = 1'b1;
    repeat (4) step(1'b0, '0, "R1 idle after reset");

    // R7 first address equal to stride is sequential
    step(1'b1, W'(STRIDE), "R7");
    step(1'b1, 16'h1230, "R3 explicit");
    step(1'b0, 16'hdead, "R6 idle");
    step(1'b1, 16'h1234, "R2 seq after idle");

    // R8 unbroken run, no address line toggles
    step(1'b1, 16'h4000, "R3 run start");
    run_start = bus_addr;
    toggles = 0;
    cur = 16'h4000;
    for (int i = 0; i < 20; i++) begin
      cur = next_addr(cur);
      step(1'b1, cur, "R2 run");
      toggles += $countones(bus_addr ^ run_start);
    end
    chk(toggles == 0, "R8 toggles in run", 32'(toggles), 0);

    // R5 wraparound
    step(1'b1, 16'hfff8, "R3 near top");
    step(1'b1, 16'hfffc, "R2 top");
    step(1'b1, 16'h0000, "R5 wrap");
    chk(bus_inc == 1'b1, "R5 wrap flag", 32'(bus_inc), 1);
    step(1'b1, 16'h0004, "R5 after wrap");

    // constrained random mix
    cur = 16'h0100;
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 5) begin
        cur = next_addr(cur);
        step(1'b1, cur, "R2 random seq");
      end else if (r < 7) begin
        step(1'b0, W'($urandom), "R6 random idle");
      end else begin
        cur = W'($urandom);
        step(1'b1, cur, "R3 random jump");
      end
    end
    step(1'b0, '0, "R6 drain");
    step(1'b0, '0, "R6 drain");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule